// File: doc/BRIEF.md
# Serial Character Transceiver with Mode Register

This block moves 8-bit characters over a single-wire serial line in each direction. A small mode register, loaded through a write strobe, chooses how each character is framed. The choices are asynchronous or clocked-synchronous operation, one or two stop bits, an optional even or odd parity bit, and a multiprocessor flag bit that takes the place of parity. The same register also selects a prescaler in front of the baud generator. An 8-bit divisor input sets the bit rate.

The transmitter takes one character per `tx_valid`/`tx_ready` handshake and shifts it out least significant bit first. The receiver watches its line, samples each bit near its middle at 16x oversampling, and holds the finished character with its status flags until `rx_read` is pulsed.

In synchronous mode the block acts as the clock master. It drives `sclk` and captures one received bit on each rising edge of `sclk`.

Top module: `serial_mode_xcvr`

## Requirements
- R1: The mode register fields are: bit 0 synchronous enable, bit 1 two stop bits, bit 2 multiprocessor enable, bit 3 parity enable, bit 4 odd parity, and bits 6:5 prescaler select. Reset clears the register, which gives one stop bit, multiprocessor off and prescaler select 00. After reset, `tx_ready`=1, `txd`=1, `sclk`=0, `rx_valid`=0 and `rx_overrun`=0.
- R2: An asynchronous frame is a start bit (0), then 8 data bits least significant first, then the optional extra bit, then the stop bits (1). `txd` rests at 1 while idle. A character is accepted on a clock edge where `tx_valid` and `tx_ready` are both high, and `tx_ready` is then low until the frame ends.
- R3: With mode bit 1 = 0 the transmitter sends one stop bit. With mode bit 1 = 1 it sends two stop bits. `tx_ready` returns high exactly at the end of the last stop bit.
- R4: With parity enabled (bit 3 = 1) and multiprocessor mode off, a parity bit follows the data. That bit makes the XOR of the data and parity equal to mode bit 4 (0 = even, 1 = odd). A received character that violates this sets `rx_par_err`.
- R5: With multiprocessor mode on (bit 2 = 1), the bit after the data is `tx_mpb`, and the receiver reports it on `rx_mpb`. In this mode the parity enable and odd settings have no effect on either side.
- R6: One bit lasts P*(divisor+1)*16 clock cycles. P is 1, 4, 16 or 64 for prescaler select 00, 01, 10 and 11.
- R7: The receiver checks only the first stop bit, whatever the stop setting. A 0 where a second stop bit would be is taken as the start bit of the next character.
- R8: A first stop bit sampled as 0 sets `rx_frame_err` for that character.
- R9: If a character completes while an unread one is held, `rx_overrun` is set and the held character is kept unchanged. Pulsing `rx_read` clears both `rx_valid` and `rx_overrun`.
- R10: In synchronous mode a frame is exactly 8 data bits, least significant first, with no start, stop, parity or multiprocessor bit. The stop and multiprocessor settings are ignored. `sclk` is low in the first half of each bit and high in the second half. `rxd` is captured at each rising edge of `sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Load strobe for the mode register |
| mode_din | input | 7 | New mode register value |
| divisor | input | 8 | Bit-rate divisor |
| tx_valid | input | 1 | Transmit character offered |
| tx_data | input | 8 | Transmit character |
| tx_mpb | input | 1 | Multiprocessor bit for the transmit character |
| tx_ready | output | 1 | Transmitter idle, able to accept |
| txd | output | 1 | Serial transmit line |
| sclk | output | 1 | Serial clock in synchronous mode |
| rxd | input | 1 | Serial receive line |
| rx_read | input | 1 | Consume the held character |
| rx_valid | output | 1 | A received character is held |
| rx_data | output | 8 | Received character |
| rx_mpb | output | 1 | Received multiprocessor bit |
| rx_frame_err | output | 1 | First stop bit was 0 |
| rx_par_err | output | 1 | Parity mismatch |
| rx_overrun | output | 1 | A character was lost while one was held |

## Verification
Several properties are checked on every cycle: the transmit handshake, the idle mark level, the start bit that follows an asynchronous accept, a quiet `sclk` while idle, the stability of a held character, and the link between the overrun flag and the valid flag. Other behaviour cannot be seen one cycle at a time and is shown only by the bench's scenarios. This covers the exact stop-bit and bit-period durations for each prescaler, the gating of parity by multiprocessor mode, and the back-to-back reception where the next start bit falls in the second stop slot. It also covers framing and parity errors, and the synchronous bit order seen at `sclk` edges.

// File: rtl/serial_mode_pkg.sv
`timescale 1ns/1ps
package serial_mode_pkg;

    localparam int MODE_W  = 7;
    localparam int PRE_W   = 6;
    localparam int OS_RATE = 16;

    typedef struct packed {
        logic [1:0] clk_sel;
        logic       par_odd;
        logic       par_en;
        logic       mp_en;
        logic       two_stop;
        logic       sync_en;
    } mode_t;

    typedef struct packed {
        logic [7:0] data;
        logic       mpb;
        logic       frame_err;
        logic       par_err;
    } rx_char_t;

    function automatic logic [PRE_W-1:0] presc_last(input logic [1:0] sel);
        case (sel)
            2'd0:    return PRE_W'(0);
            2'd1:    return PRE_W'(3);
            2'd2:    return PRE_W'(15);
            default: return PRE_W'(63);
        endcase
    endfunction

    function automatic logic has_extra(input mode_t m);
        return m.mp_en | m.par_en;
    endfunction

endpackage

// File: rtl/serial_baud_gen.sv
`timescale 1ns/1ps
module serial_baud_gen
    import serial_mode_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       clk_sel,
    input  logic [DIV_W-1:0] divisor,
    output logic             os_tick
);
    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic             pre_tick;

    assign pre_tick = (pre_cnt >= presc_last(clk_sel));
    assign os_tick  = pre_tick && (div_cnt >= divisor);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else begin
            pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
            if (pre_tick)
                div_cnt <= (div_cnt >= divisor) ? '0 : div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/serial_tx.sv
`timescale 1ns/1ps
module serial_tx
    import serial_mode_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_t             mode,
    input  logic              os_tick,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_mpb,
    output logic              tx_ready,
    output logic              txd,
    output logic              sclk,
    output logic              samp_stb
);
    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(OS_RATE);
    localparam int IDX_W   = $clog2(FRAME_W + 1);
    localparam int MID     = OS_RATE / 2 - 1;

    logic               busy;
    logic               txd_q;
    logic [FRAME_W-1:0] sh;
    logic [IDX_W-1:0]   left;
    logic [CNT_W-1:0]   os_cnt;
    logic [FRAME_W-1:0] frame;
    logic [IDX_W-1:0]   nbits;
    logic               extra_bit;

    always_comb begin
        extra_bit = mode.mp_en ? tx_mpb : ((^tx_data) ^ mode.par_odd);
        frame     = '1;
        if (mode.sync_en) begin
            frame[DATA_W-1:0] = tx_data;
            nbits = IDX_W'(DATA_W);
        end else begin
            frame[0]        = 1'b0;
            frame[DATA_W:1] = tx_data;
            if (has_extra(mode))
                frame[DATA_W+1] = extra_bit;
            nbits = IDX_W'(DATA_W + 2) + IDX_W'(has_extra(mode)) + IDX_W'(mode.two_stop);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            txd_q  <= 1'b1;
            sh     <= '1;
            left   <= '0;
            os_cnt <= '0;
        end else if (!busy) begin
            if (tx_valid) begin
                busy   <= 1'b1;
                txd_q  <= frame[0];
                sh     <= {1'b1, frame[FRAME_W-1:1]};
                left   <= nbits - 1'b1;
                os_cnt <= '0;
            end
        end else if (os_tick) begin
            os_cnt <= os_cnt + 1'b1;
            if (os_cnt == CNT_W'(OS_RATE - 1)) begin
                if (left == '0) begin
                    busy  <= 1'b0;
                    txd_q <= 1'b1;
                end else begin
                    txd_q <= sh[0];
                    sh    <= {1'b1, sh[FRAME_W-1:1]};
                    left  <= left - 1'b1;
                end
            end
        end
    end

    assign tx_ready = !busy;
    assign txd      = txd_q;
    assign sclk     = busy & mode.sync_en & os_cnt[CNT_W-1];
    assign samp_stb = busy & mode.sync_en & os_tick & (os_cnt == CNT_W'(MID));
endmodule

// File: rtl/serial_rx.sv
`timescale 1ns/1ps
module serial_rx
    import serial_mode_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  mode_t    mode,
    input  logic     os_tick,
    input  logic     rxd,
    input  logic     samp_stb,
    input  logic     rx_read,
    output logic     rx_valid,
    output rx_char_t rx_char,
    output logic     rx_overrun
);
    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(OS_RATE);
    localparam int IDX_W   = $clog2(FRAME_W + 1);
    localparam int MID     = OS_RATE / 2 - 1;

    logic [1:0]        sync_q;
    logic              rxs;
    logic              run;
    logic [CNT_W-1:0]  os_cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] dsh;
    logic [DATA_W-1:0] dsh_next;
    logic              extra_q;
    logic [IDX_W-1:0]  stop_idx;
    logic              mid;
    logic              done;
    rx_char_t          done_char;

    assign rxs      = sync_q[1];
    assign dsh_next = {rxs, dsh[DATA_W-1:1]};
    assign stop_idx = IDX_W'(DATA_W + 1) + IDX_W'(has_extra(mode));
    assign mid      = run && os_tick && (os_cnt == CNT_W'(MID));

    always_comb begin
        if (mode.sync_en) begin
            done           = samp_stb && (idx == IDX_W'(DATA_W - 1));
            done_char      = '0;
            done_char.data = dsh_next;
        end else begin
            done                = mid && (idx == stop_idx);
            done_char.data      = dsh;
            done_char.mpb       = mode.mp_en & extra_q;
            done_char.frame_err = !rxs;
            done_char.par_err   = mode.par_en & !mode.mp_en & (((^dsh) ^ extra_q) != mode.par_odd);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 2'b11;
            run     <= 1'b0;
            os_cnt  <= '0;
            idx     <= '0;
            dsh     <= '0;
            extra_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], rxd};
            if (mode.sync_en) begin
                run    <= 1'b0;
                os_cnt <= '0;
                if (samp_stb) begin
                    dsh <= dsh_next;
                    idx <= (idx == IDX_W'(DATA_W - 1)) ? '0 : idx + 1'b1;
                end
            end else if (!run) begin
                idx    <= '0;
                os_cnt <= '0;
                if (!rxs)
                    run <= 1'b1;
            end else if (os_tick) begin
                os_cnt <= os_cnt + 1'b1;
                if (os_cnt == CNT_W'(MID)) begin
                    if ((idx == '0 && rxs) || idx == stop_idx) begin
                        run <= 1'b0;
                    end else begin
                        if (idx <= IDX_W'(DATA_W) && idx != '0)
                            dsh <= dsh_next;
                        else if (idx != '0)
                            extra_q <= rxs;
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid   <= 1'b0;
            rx_char    <= '0;
            rx_overrun <= 1'b0;
        end else if (done) begin
            if (rx_valid && !rx_read) begin
                rx_overrun <= 1'b1;
            end else begin
                rx_char    <= done_char;
                rx_valid   <= 1'b1;
                rx_overrun <= 1'b0;
            end
        end else if (rx_read) begin
            rx_valid   <= 1'b0;
            rx_overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_mode_xcvr.sv
`timescale 1ns/1ps
module serial_mode_xcvr
    import serial_mode_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_din,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_mpb,
    output logic              tx_ready,
    output logic              txd,
    output logic              sclk,
    input  logic              rxd,
    input  logic              rx_read,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_mpb,
    output logic              rx_frame_err,
    output logic              rx_par_err,
    output logic              rx_overrun
);
    mode_t    mode_q;
    logic     os_tick;
    logic     samp_stb;
    logic     mode_sync_w;
    rx_char_t rx_char;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else if (mode_we)
            mode_q <= mode_t'(mode_din);
    end

    assign mode_sync_w = mode_q.sync_en;

    serial_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .clk_sel(mode_q.clk_sel),
        .divisor(divisor), .os_tick(os_tick)
    );

    serial_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst(rst), .mode(mode_q), .os_tick(os_tick),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_mpb(tx_mpb),
        .tx_ready(tx_ready), .txd(txd), .sclk(sclk), .samp_stb(samp_stb)
    );

    serial_rx #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst(rst), .mode(mode_q), .os_tick(os_tick),
        .rxd(rxd), .samp_stb(samp_stb), .rx_read(rx_read),
        .rx_valid(rx_valid), .rx_char(rx_char), .rx_overrun(rx_overrun)
    );

    assign rx_data      = rx_char.data;
    assign rx_mpb       = rx_char.mpb;
    assign rx_frame_err = rx_char.frame_err;
    assign rx_par_err   = rx_char.par_err;
endmodule

// File: rtl/serial_mode_chk.sv
`timescale 1ns/1ps
module serial_mode_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              txd,
    input logic              sclk,
    input logic              rx_valid,
    input logic              rx_read,
    input logic              rx_overrun,
    input logic [DATA_W-1:0] rx_data,
    input logic              sync_mode
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (tx_ready && txd && !sclk && !rx_valid && !rx_overrun));

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready);

    p_idle_mark_r2: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> txd);

    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && !sync_mode) |=> !txd);

    p_data_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_read) |=> $stable(rx_data));

    p_overrun_valid_r9: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |-> rx_valid);

    p_sclk_idle_r10: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> !sclk);
endmodule

bind serial_mode_xcvr serial_mode_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .txd(txd), .sclk(sclk), .rx_valid(rx_valid), .rx_read(rx_read),
    .rx_overrun(rx_overrun), .rx_data(rx_data), .sync_mode(mode_sync_w)
);

// File: tb/serial_mode_xcvr_test.sv
`timescale 1ns/1ps
module serial_mode_xcvr_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_we = 1'b0;
    logic [6:0] mode_din = '0;
    logic [7:0] divisor = '0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_mpb = 1'b0;
    logic       tx_ready, txd, sclk;
    logic       rxd;
    logic       rx_read = 1'b0;
    logic       rx_valid, rx_mpb, rx_frame_err, rx_par_err, rx_overrun;
    logic [7:0] rx_data;

    logic use_loop = 1'b1;
    logic bb_line  = 1'b1;
    logic auto_rd  = 1'b1;
    logic rd_req   = 1'b0;
    int   n_chk = 0, n_fail = 0;
    int   cyc = 0;
    string cur_req = "R2";

    typedef struct packed {
        logic [7:0] data;
        logic       mpb;
        logic       ferr;
        logic       perr;
    } exp_t;
    exp_t exp_q[$];

    assign rxd = use_loop ? txd : bb_line;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serial_mode_xcvr uut (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_din(mode_din),
        .divisor(divisor), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_mpb(tx_mpb), .tx_ready(tx_ready), .txd(txd), .sclk(sclk),
        .rxd(rxd), .rx_read(rx_read), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_mpb(rx_mpb), .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err),
        .rx_overrun(rx_overrun)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard when a character is held
    always @(negedge clk) begin
        rx_read = 1'b0;
        if (rd_req) begin
            rx_read = 1'b1;
            rd_req  = 1'b0;
        end else if (auto_rd && rx_valid) begin
            if (exp_q.size() == 0) begin
                chk(cur_req, "unexpected character", int'(rx_data), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(cur_req, "rx_data", int'(rx_data), int'(e.data));
                chk(cur_req, "rx_mpb", int'(rx_mpb), int'(e.mpb));
                chk(cur_req, "rx_frame_err", int'(rx_frame_err), int'(e.ferr));
                chk(cur_req, "rx_par_err", int'(rx_par_err), int'(e.perr));
                chk(cur_req, "rx_overrun", int'(rx_overrun), 0);
            end
            rx_read = 1'b1;
        end
    end

    function automatic logic [6:0] mk_mode(input logic [1:0] sel, input logic odd,
                                           input logic pen, input logic mp,
                                           input logic two, input logic syn);
        return {sel, odd, pen, mp, two, syn};
    endfunction

    task automatic set_mode(input logic [6:0] m, input logic [7:0] d);
        @(negedge clk);
        mode_we = 1'b1; mode_din = m; divisor = d;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] d, input logic m, input logic fe, input logic pe);
        exp_q.push_back({d, m, fe, pe});
    endtask

    task automatic send(input logic [7:0] d, input logic m);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_valid = 1'b1; tx_data = d; tx_mpb = m;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_val(input logic want);
        while (txd != want) @(negedge clk);
    endtask

    task automatic settle();
        @(negedge clk);
        while (!tx_ready || exp_q.size() != 0) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    // data 0: measures from the first 1 after the start bit to tx_ready
    task automatic tail_len(input logic m, output int len);
        int t1;
        send(8'h00, m);
        wait_val(1'b0);
        wait_val(1'b1);
        t1 = cyc;
        while (!tx_ready) @(negedge clk);
        len = cyc - t1;
    endtask

    // data 0x02: d1 is the only 1, its length is one bit period
    task automatic bit_len(output int len);
        int t1;
        send(8'h02, 1'b0);
        wait_val(1'b0);
        wait_val(1'b1);
        t1 = cyc;
        wait_val(1'b0);
        len = cyc - t1;
        while (!tx_ready) @(negedge clk);
    endtask

    task automatic bb_bits(input logic [15:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            bb_line = bits[i];
            repeat (16) @(negedge clk);
        end
        bb_line = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int len;
        logic [7:0] got;
        int edges;
        logic prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "tx_ready", int'(tx_ready), 1);
        chk("R1", "txd", int'(txd), 1);
        chk("R1", "sclk", int'(sclk), 0);
        chk("R1", "rx_valid", int'(rx_valid), 0);
        chk("R1", "rx_overrun", int'(rx_overrun), 0);
        // R1 default mode: one stop, select 00 (16 clocks per bit)
        cur_req = "R1";
        push(8'h00, 1'b0, 1'b0, 1'b0);
        tail_len(1'b0, len);
        chk("R1", "default stop length", len, 16);
        settle();

        // R2 loopback of several patterns
        cur_req = "R2";
        push(8'hA5, 0, 0, 0); send(8'hA5, 0);
        push(8'h3C, 0, 0, 0); send(8'h3C, 0);
        push(8'hFF, 0, 0, 0); send(8'hFF, 0);
        push(8'h01, 0, 0, 0); send(8'h01, 0);
        settle();

        // R3 stop bit count
        cur_req = "R3";
        set_mode(mk_mode(2'd0, 0, 0, 0, 1, 0), 8'd0);
        push(8'h00, 0, 0, 0);
        tail_len(1'b0, len);
        chk("R3", "two stop length", len, 32);
        settle();
        set_mode(mk_mode(2'd0, 0, 0, 0, 0, 0), 8'd0);
        push(8'h00, 0, 0, 0);
        tail_len(1'b0, len);
        chk("R3", "one stop length", len, 16);
        settle();

        // R4 parity
        cur_req = "R4";
        set_mode(mk_mode(2'd0, 0, 1, 0, 0, 0), 8'd0);
        push(8'h00, 0, 0, 0);
        tail_len(1'b0, len);
        chk("R4", "even parity of 0 is 0", len, 16);
        settle();
        set_mode(mk_mode(2'd0, 1, 1, 0, 0, 0), 8'd0);
        push(8'h00, 0, 0, 0);
        tail_len(1'b0, len);
        chk("R4", "odd parity of 0 is 1", len, 32);
        push(8'h5B, 0, 0, 0); send(8'h5B, 0);
        settle();
        set_mode(mk_mode(2'd0, 0, 1, 0, 0, 0), 8'd0);
        use_loop = 1'b0;
        push(8'h01, 0, 0, 1);
        bb_bits({5'b0, 1'b1, 1'b0, 8'h01, 1'b0}, 11);
        push(8'h01, 0, 0, 0);
        bb_bits({5'b0, 1'b1, 1'b1, 8'h01, 1'b0}, 11);
        settle();
        use_loop = 1'b1;

        // R5 multiprocessor bit, parity settings ignored
        cur_req = "R5";
        set_mode(mk_mode(2'd0, 1, 1, 1, 0, 0), 8'd0);
        push(8'h00, 0, 0, 0);
        tail_len(1'b0, len);
        chk("R5", "mpb 0 no parity bit", len, 16);
        settle();
        push(8'h00, 1, 0, 0);
        tail_len(1'b1, len);
        chk("R5", "mpb 1 length", len, 32);
        push(8'hA5, 1, 0, 0); send(8'hA5, 1);
        push(8'h5A, 0, 0, 0); send(8'h5A, 0);
        settle();

        // R6 prescaler and divisor
        cur_req = "R6";
        set_mode(mk_mode(2'd0, 0, 0, 0, 0, 0), 8'd0);
        push(8'h02, 0, 0, 0); bit_len(len); chk("R6", "sel 00 bit", len, 16); settle();
        set_mode(mk_mode(2'd1, 0, 0, 0, 0, 0), 8'd0);
        push(8'h02, 0, 0, 0); bit_len(len); chk("R6", "sel 01 bit", len, 64); settle();
        set_mode(mk_mode(2'd2, 0, 0, 0, 0, 0), 8'd0);
        push(8'h02, 0, 0, 0); bit_len(len); chk("R6", "sel 10 bit", len, 256); settle();
        set_mode(mk_mode(2'd3, 0, 0, 0, 0, 0), 8'd0);
        push(8'h02, 0, 0, 0); bit_len(len); chk("R6", "sel 11 bit", len, 1024); settle();
        set_mode(mk_mode(2'd1, 0, 0, 0, 0, 0), 8'd2);
        push(8'h02, 0, 0, 0); bit_len(len); chk("R6", "sel 01 div 2 bit", len, 192); settle();

        // R7 second stop slot carries the next start bit
        cur_req = "R7";
        set_mode(mk_mode(2'd0, 0, 0, 0, 1, 0), 8'd0);
        use_loop = 1'b0;
        push(8'h3C, 0, 0, 0);
        push(8'hC3, 0, 0, 0);
        bb_bits({6'b0, 1'b1, 8'h3C, 1'b0}, 10);
        bb_bits({5'b0, 2'b11, 8'hC3, 1'b0}, 11);
        settle();

        // R8 framing error
        cur_req = "R8";
        set_mode(mk_mode(2'd0, 0, 0, 0, 0, 0), 8'd0);
        push(8'h81, 0, 1, 0);
        bb_bits({6'b0, 1'b0, 8'h81, 1'b0}, 10);
        bb_bits(16'h0007, 3);
        settle();
        use_loop = 1'b1;

        // R9 overrun keeps the first character
        auto_rd = 1'b0;
        send(8'h11, 0);
        send(8'h22, 0);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        repeat (20) @(negedge clk);
        chk("R9", "rx_valid held", int'(rx_valid), 1);
        chk("R9", "rx_overrun set", int'(rx_overrun), 1);
        chk("R9", "first char kept", int'(rx_data), 8'h11);
        rd_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9", "rx_valid cleared", int'(rx_valid), 0);
        chk("R9", "rx_overrun cleared", int'(rx_overrun), 0);
        auto_rd = 1'b1;

        // R10 synchronous mode, stop and mp settings ignored
        cur_req = "R10";
        set_mode(mk_mode(2'd0, 0, 0, 1, 1, 1), 8'd0);
        push(8'hB4, 0, 0, 0);
        send(8'hB4, 0);
        got = '0; edges = 0; prev = sclk;
        while (!tx_ready) begin
            if (sclk && !prev) begin
                got = {txd, got[7:1]};
                edges++;
            end
            prev = sclk;
            @(negedge clk);
        end
        chk("R10", "sclk rising edges", edges, 8);
        chk("R10", "bits at sclk", int'(got), 8'hB4);
        settle();
        push(8'h6E, 0, 0, 0);
        send(8'h6E, 0);
        settle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule